// File: doc/BRIEF.md
# Maskable Four-Source UART Interrupt Combiner

This block merges four status conditions of a serial port core into one active-low interrupt request line. Two of the conditions are levels that the core holds while they are true: the transmit holding buffer is empty, and received data is waiting to be fetched. The other two are events that the block captures when a received word arrives. One event is a parity bit that arrives set. The other has two meanings that depend on the power state. While the port is in software shutdown, it is any activity seen on the receive line. During normal operation, it is a word that arrives with a framing error.

Each source has its own enable bit. The enable bits are loaded from the configuration word when the serial host interface signals that a configuration write has completed. A new mask applies from the next clock. It does not wait for a transmission in progress to finish. Captured events stay pending until the host makes a data access (a read or a write of the data register). Such an access discards them only if no new triggering event arrives in the same cycle. The level sources need no clearing: they stop requesting as soon as the core drops them.

All ports are plain control and status pins. No data stream passes through the block, so it has no valid/ready interface and applies no back-pressure.

Top module: `uart_irq_gen`

## Requirements
- R1: While reset is asserted, all four enable bits are 0, both captured events are cleared and `irq_n` is 1.
- R2: A cycle with `cfg_wr` high loads the enable bits from `cfg_word[11:8]` at that clock edge. Bit 11 enables transmit-empty, bit 10 data-available, bit 9 parity-high and bit 8 activity/framing. Word 0xC80A therefore enables only transmit-empty, and 0xC40A enables only data-available. The new mask governs `irq_n` from the cycle after the edge. When `cfg_wr` is low the mask is held.
- R3: When transmit-empty is enabled, `irq_n` is low in every cycle in which `tx_empty` is high, with no register delay. It stops requesting in the same cycle that `tx_empty` falls.
- R4: When data-available is enabled, `irq_n` is low in every cycle in which `rx_avail` is high, with no register delay.
- R5: A cycle with `word_arrive` and `word_par` both high captures a parity-high event. The event is visible on `irq_n` from the next cycle when that source is enabled.
- R6: With `shutdown` high, `rx_activity` captures the activity/framing event and `word_frm_err` is ignored. With `shutdown` low, `word_arrive` together with `word_frm_err` captures the event and `rx_activity` is ignored.
- R7: A cycle with `data_acc` high clears each captured event whose trigger is absent in that cycle. If a trigger is present in the same cycle, the event stays pending (set wins).
- R8: Events are captured even while their source is disabled. Enabling the source later raises the request without a new event.
- R9: `irq_n` is low exactly when at least one enabled source is requesting. A `cfg_wr` without `data_acc` clears no captured event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | One-cycle strobe: a configuration write has completed |
| cfg_word | input | 16 | The configuration word received; bits 11:8 are the enables |
| tx_empty | input | 1 | Level: transmit holding buffer empty |
| rx_avail | input | 1 | Level: received data waiting |
| word_arrive | input | 1 | One-cycle strobe: a received word has been stored |
| word_par | input | 1 | Parity bit of the arriving word |
| word_frm_err | input | 1 | Framing error on the arriving word |
| shutdown | input | 1 | Level: software shutdown active |
| rx_activity | input | 1 | Strobe: edge seen on the receive line |
| data_acc | input | 1 | One-cycle strobe: data register read or write |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The bench builds the block with its default parameters: a 16-bit configuration word whose enable field starts at bit 8. With those defaults, the two sample configuration words from R2 drive the decode directly. It also reaches every combination of the four enables, the shutdown-dependent meaning of the shared source, and data accesses that collide with new events in the same cycle. Random traffic with all four sources active at once is scored against a cycle model kept in the bench.

// File: rtl/uart_irq_gen_pkg.sv
package uart_irq_gen_pkg;
  // Index of each source in the enable and request vectors.
  localparam int NSRC    = 4;
  localparam int IDX_RAF = 0;  // activity in shutdown / framing error
  localparam int IDX_PAR = 1;  // parity bit high
  localparam int IDX_RXA = 2;  // receive data available
  localparam int IDX_TXE = 3;  // transmit buffer empty
  localparam int NEVT    = 2;  // captured event sources occupy indices 0..NEVT-1
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int CFG_W    = 16,
  parameter int MASK_LSB = 8,
  parameter int NSRC     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CFG_W-1:0] cfg,
  output logic [NSRC-1:0]  mask
);
  localparam int MASK_MSB = MASK_LSB + NSRC - 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask <= '0;
    else if (load) mask <= cfg[MASK_MSB:MASK_LSB];
  end
endmodule

// File: rtl/irq_event_latch.sv
module irq_event_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic pend
);
  // A new event in the clearing cycle keeps the source pending.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend <= 1'b0;
    else if (set) pend <= 1'b1;
    else if (clr) pend <= 1'b0;
  end
endmodule

// File: rtl/irq_raf_select.sv
module irq_raf_select (
  input  logic shutdown,
  input  logic rx_activity,
  input  logic word_arrive,
  input  logic word_frm_err,
  output logic trig
);
  // The shared source changes meaning with the power state.
  always_comb begin
    if (shutdown) trig = rx_activity;
    else          trig = word_arrive & word_frm_err;
  end
endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen
  import uart_irq_gen_pkg::*;
#(
  parameter int CFG_W    = 16,
  parameter int MASK_LSB = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             tx_empty,
  input  logic             rx_avail,
  input  logic             word_arrive,
  input  logic             word_par,
  input  logic             word_frm_err,
  input  logic             shutdown,
  input  logic             rx_activity,
  input  logic             data_acc,
  output logic             irq_n
);
  logic [NSRC-1:0] mask_q;
  logic [NEVT-1:0] evt_set;
  logic [NEVT-1:0] evt_pend;
  logic [NSRC-1:0] src_req;
  logic            raf_trig;

  irq_mask_reg #(.CFG_W(CFG_W), .MASK_LSB(MASK_LSB), .NSRC(NSRC)) u_mask (
    .clk  (clk),
    .rst_n(rst_n),
    .load (cfg_wr),
    .cfg  (cfg_word),
    .mask (mask_q)
  );

  irq_raf_select u_raf (
    .shutdown    (shutdown),
    .rx_activity (rx_activity),
    .word_arrive (word_arrive),
    .word_frm_err(word_frm_err),
    .trig        (raf_trig)
  );

  always_comb begin
    evt_set          = '0;
    evt_set[IDX_RAF] = raf_trig;
    evt_set[IDX_PAR] = word_arrive & word_par;
  end

  for (genvar g = 0; g < NEVT; g++) begin : g_evt
    irq_event_latch u_lat (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (evt_set[g]),
      .clr  (data_acc),
      .pend (evt_pend[g])
    );
  end

  always_comb begin
    src_req               = '0;
    src_req[NEVT-1:0]     = evt_pend;
    src_req[IDX_RXA]      = rx_avail;
    src_req[IDX_TXE]      = tx_empty;
  end

  assign irq_n = ~|(mask_q & src_req);
endmodule

// File: rtl/uart_irq_gen_chk.sv
module uart_irq_gen_chk
  import uart_irq_gen_pkg::*;
#(
  parameter int CFG_W    = 16,
  parameter int MASK_LSB = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic [CFG_W-1:0] cfg_word,
  input logic             tx_empty,
  input logic             word_arrive,
  input logic             word_par,
  input logic             data_acc,
  input logic [NSRC-1:0]  mask_q,
  input logic [NEVT-1:0]  evt_pend,
  input logic             irq_n
);
  // R1
  always_comb begin
    if (!rst_n) begin
      reset_idle_chk: assert (irq_n == 1'b1 && mask_q == '0);
    end
  end

  // R2
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> mask_q == $past(cfg_word[MASK_LSB +: NSRC]));

  // R3
  txe_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q[IDX_TXE] && tx_empty) |-> !irq_n);

  // R5
  par_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_arrive && word_par) |=> evt_pend[IDX_PAR]);

  // R7
  par_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !(word_arrive && word_par)) |=> !evt_pend[IDX_PAR]);

  // R9
  all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> irq_n);
endmodule

bind uart_irq_gen uart_irq_gen_chk #(.CFG_W(CFG_W), .MASK_LSB(MASK_LSB)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wr     (cfg_wr),
  .cfg_word   (cfg_word),
  .tx_empty   (tx_empty),
  .word_arrive(word_arrive),
  .word_par   (word_par),
  .data_acc   (data_acc),
  .mask_q     (mask_q),
  .evt_pend   (evt_pend),
  .irq_n      (irq_n)
);

// File: tb/uart_irq_gen_tb.sv
module uart_irq_gen_tb;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_word = '0;
  logic        tx_empty = 1'b0, rx_avail = 1'b0;
  logic        word_arrive = 1'b0, word_par = 1'b0, word_frm_err = 1'b0;
  logic        shutdown = 1'b0, rx_activity = 1'b0, data_acc = 1'b0;
  logic        irq_n;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  // bench model: m[3]=tx-empty, m[2]=data-avail, m[1]=parity, m[0]=act/frm
  logic [3:0] m_mask = '0;
  logic       m_par = 1'b0, m_raf = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  uart_irq_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
    .tx_empty(tx_empty), .rx_avail(rx_avail), .word_arrive(word_arrive),
    .word_par(word_par), .word_frm_err(word_frm_err), .shutdown(shutdown),
    .rx_activity(rx_activity), .data_acc(data_acc), .irq_n(irq_n)
  );

  function automatic logic exp_irq_n();
    return ~|(m_mask & {tx_empty, rx_avail, m_par, m_raf});
  endfunction

  function automatic logic raf_trigger();
    return shutdown ? rx_activity : (word_arrive & word_frm_err);
  endfunction

  task automatic check(string req, logic act, logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: irq_n=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_inputs();
    cfg_wr = 0; word_arrive = 0; word_par = 0; word_frm_err = 0;
    rx_activity = 0; data_acc = 0;
  endtask

  // Inputs are set by the caller; check, advance the model, move one cycle.
  task automatic cyc(string req);
    logic ps, rs;
    #1;
    check(req, irq_n, exp_irq_n());
    ps = word_arrive & word_par;
    rs = raf_trigger();
    m_par = ps ? 1'b1 : (data_acc ? 1'b0 : m_par);
    m_raf = rs ? 1'b1 : (data_acc ? 1'b0 : m_raf);
    if (cfg_wr) m_mask = cfg_word[11:8];
    @(negedge clk);
    #1;
    clear_inputs();
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: expired, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tx_empty = 1; rx_avail = 1;
    #1 check("R1 reset", irq_n, 1'b1);
    @(negedge clk); rst_n = 1; #1;

    // R2: 0xC80A enables only transmit-empty
    tx_empty = 0; rx_avail = 1;
    cfg_wr = 1; cfg_word = 16'hC80A;
    cyc("R2 before load");
    rx_avail = 1; cyc("R2 C80A rx ignored");
    check("R2 C80A rx ignored const", irq_n, 1'b1);
    tx_empty = 1; cyc("R3 tx empty asserts");
    check("R3 tx const", irq_n, 1'b0);
    tx_empty = 0; cyc("R3 tx drop same cycle");
    check("R3 tx drop const", irq_n, 1'b1);

    // R4: 0xC40A enables only data-available
    cfg_wr = 1; cfg_word = 16'hC40A; cyc("R2 load C40A");
    tx_empty = 1; rx_avail = 0; cyc("R2 C40A tx ignored");
    check("R2 C40A tx const", irq_n, 1'b1);
    rx_avail = 1; cyc("R4 rx avail");
    check("R4 rx const", irq_n, 1'b0);
    rx_avail = 0; tx_empty = 0;

    // R8: parity event captured while masked
    word_arrive = 1; word_par = 1; cyc("R5 arrive masked");
    cyc("R8 masked stays high");
    check("R8 masked const", irq_n, 1'b1);
    cfg_wr = 1; cfg_word = 16'h0200; cyc("R8 enable parity");
    cyc("R8 pending shows");
    check("R8 pending const", irq_n, 1'b0);
    // R9: cfg write alone does not clear
    cfg_wr = 1; cfg_word = 16'h0200; cyc("R9 cfg no clear");
    check("R9 cfg no clear const", irq_n, 1'b0);
    // R7: access with collision keeps pending
    data_acc = 1; word_arrive = 1; word_par = 1; cyc("R7 collide");
    check("R7 collide const", irq_n, 1'b0);
    data_acc = 1; cyc("R7 clear");
    check("R7 clear const", irq_n, 1'b1);

    // R6: shared source semantics
    cfg_wr = 1; cfg_word = 16'h0100; cyc("R6 enable raf");
    shutdown = 0; rx_activity = 1; cyc("R6 activity ignored normal");
    check("R6 activity ignored const", irq_n, 1'b1);
    shutdown = 1; word_arrive = 1; word_frm_err = 1; cyc("R6 frame ignored shutdown");
    check("R6 frame ignored const", irq_n, 1'b1);
    rx_activity = 1; cyc("R6 activity in shutdown");
    check("R6 activity const", irq_n, 1'b0);
    data_acc = 1; cyc("R7 clear raf");
    shutdown = 0; word_arrive = 1; word_frm_err = 1; cyc("R6 frame normal");
    check("R6 frame const", irq_n, 1'b0);
    data_acc = 1; cyc("R7 clear frame");
    check("R7 clear frame const", irq_n, 1'b1);

    // R9: random mix against the model
    void'($urandom(32'h5EED));
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom();
      cfg_wr       = (r[3:0] == 0);
      cfg_word     = $urandom();
      tx_empty     = r[4];
      rx_avail     = r[5];
      word_arrive  = (r[8:6] == 0);
      word_par     = r[9];
      word_frm_err = r[10];
      if (r[15:11] == 0) shutdown = ~shutdown;
      rx_activity  = (r[18:16] == 0);
      data_acc     = (r[21:19] == 0);
      cyc("R9 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule